// File: doc/BRIEF.md
# Regulator Calibration Control Sequencer

This block sequences the self-calibration of a sleep-mode voltage regulator. It has two sides. The bus side is a small register file on a fast clock. The calibration side steps through a binary search on a slow clock. The slow clock is a free-running oscillator reduced by a clock-enable divider. Once the start-up indication arrives, the calibration side runs a 16-step successive-approximation search against a one-bit comparator input, starting at the most significant bit. It then repeats the search cycle after cycle. The search stops at a cycle boundary when deep sleep is requested, and a fresh search begins when the sleep request is withdrawn. During a search the regulator sees the trial code. At all other times it sees the last result. A larger code means a lower regulator voltage in sleep.

The deep-sleep request only reaches the power-down output once a first full search has finished. Software can clear the enable bit, after which it may overwrite the result code and the two trim bits. Every accepted bus write travels to the slow side through a toggle handshake, and a busy flag reports the crossing. Each completed result returns to the bus side as one atomic capture. Because of this, the two bytes read back always belong to the same search.

Top module: `regcal_seq`

## Requirements
- R1: After reset the control register (address 0) reads 0x01. Its fields are bit 0 enable, bit 1 temperature trim, bit 2 short trim, bit 6 busy and bit 7 done. The low data byte (address 1) and the high data byte (address 2) read 0x00, and powerDown is 0.
- R2: While enabled and once startupDone is high, the block runs a 16-step search, one step per slow tick, MSB first. Each trial bit is kept when cmpHigh is 1 and cleared when it is 0. Against a comparator that is high while the code is at or below a target, the result equals the target, including 0x0000 and 0xFFFF.
- R3: When a search completes, the done bit (bit 7) sets and stays set. Data bytes 1 and 2 then show the result of that search.
- R4: powerDown stays 0 while sleepReq is high until the first search has completed. After that, powerDown follows sleepReq, whether or not calibration is enabled.
- R5: The search repeats after the first completion. With sleepReq high it stops at the next completion, and regCode then holds the result steady whatever the comparator does.
- R6: When sleepReq falls, a new search starts, so a changed comparator target is reflected in the data bytes.
- R7: While enable is 1, writes to the data bytes are ignored. A control write changes only the enable bit and leaves both trim bits unchanged.
- R8: While enable is 0, writes to all three registers are accepted. Each accepted write sets busy (bit 6) until the slow side acknowledges. After that, regCode, regTempCo and regShort carry the written values.
- R9: Clearing enable stops any running search. regCode then holds the last completed result and ignores the comparator.
- R10: Any write issued while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock |
| busRstN | input | 1 | Bus-side asynchronous reset, active low |
| oscClk | input | 1 | Low-frequency oscillator clock; the slow tick is derived from it |
| oscRstN | input | 1 | Oscillator-side asynchronous reset, active low |
| startupDone | input | 1 | High once reset and start-up have finished |
| sleepReq | input | 1 | Deep-sleep request, bus domain |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 data low, 2 data high |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address; address 3 reads 0 |
| rdData | output | 8 | Read data |
| cmpHigh | input | 1 | Comparator decision for the current trial code |
| powerDown | output | 1 | Power-chain shutdown request |
| regCode | output | 16 | Code applied to the regulator |
| regTempCo | output | 1 | Temperature-coefficient trim to the regulator |
| regShort | output | 1 | Short trim to the regulator |

## Verification
The bench uses the default parameters: an oscillator divider of 2 and two-stage synchronizers. The oscillator period is seven times the bus period, so each handshake crossing spans many bus cycles. This leaves time to observe busy in the middle of a crossing and to issue a write during that window. With a 16-bit code and one bit per slow tick, a search takes about 224 bus cycles. That is short enough to cover the target extremes, aborted searches, sleep entry before the first result and wake-up restarts within one run.

// File: rtl/regcal_pkg.sv
package regcal_pkg;
  localparam int unsigned CodeW = 16;
  localparam int unsigned IdxW = $clog2(CodeW);

  localparam int unsigned CtrlEnBit = 0;
  localparam int unsigned CtrlTcBit = 1;
  localparam int unsigned CtrlShBit = 2;
  localparam int unsigned CtrlBusyBit = 6;
  localparam int unsigned CtrlDoneBit = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAR  = 2'd1
  } calState_t;

  // strobes from the slow controller to the code datapath
  typedef struct packed {
    logic start;     // load MSB-only trial
    logic step;      // resolve current bit from comparator
    logic last;      // this step resolves bit 0
    logic loadTrim;  // take trims from bus shadow
    logic loadData;  // take code from bus shadow
  } calStrobe_t;
endpackage

// File: rtl/regcal_sync.sv
module regcal_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stg[g] <= '0;
          else stg[g] <= d;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stg[g] <= '0;
          else stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/regcal_busif.sv
module regcal_busif
  import regcal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic [1:0]       rdAddr,
  output logic [7:0]       rdData,
  input  logic             sleepReq,
  output logic             powerDown,
  output logic             reqTgl,
  output logic             shEn,
  output logic             shTc,
  output logic             shSh,
  output logic             shIsData,
  output logic [CodeW-1:0] shData,
  input  logic             ackTglAsync,
  input  logic             doneTglAsync,
  input  logic [CodeW-1:0] resultAsync
);
  localparam int unsigned HalfW = CodeW / 2;

  logic ackS, doneS, doneSd, doneFlag, busy, accept, doneEdge;
  logic [1:0] syncOut;

  regcal_sync #(.STAGES(SYNC_STAGES), .W(2)) uSyncBack (
    .clk(clk), .rstN(rstN), .d({ackTglAsync, doneTglAsync}), .q(syncOut)
  );
  assign ackS  = syncOut[1];
  assign doneS = syncOut[0];

  assign busy     = reqTgl != ackS;
  assign doneEdge = doneS != doneSd;
  assign accept   = wrEn && !busy && (wrAddr != 2'd3) &&
                    ((wrAddr == 2'd0) || !shEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqTgl   <= 1'b0;
      shEn     <= 1'b1;
      shTc     <= 1'b0;
      shSh     <= 1'b0;
      shIsData <= 1'b0;
      shData   <= '0;
      doneSd   <= 1'b0;
      doneFlag <= 1'b0;
      powerDown <= 1'b0;
    end else begin
      doneSd    <= doneS;
      powerDown <= sleepReq && doneFlag;
      if (doneEdge) begin
        doneFlag <= 1'b1;
        // the result is stable for a whole search after its toggle
        if (shEn) shData <= resultAsync;
      end
      if (accept) begin
        reqTgl <= ~reqTgl;
        case (wrAddr)
          2'd0: begin
            shEn     <= wrData[CtrlEnBit];
            shIsData <= 1'b0;
            if (!shEn) begin
              shTc <= wrData[CtrlTcBit];
              shSh <= wrData[CtrlShBit];
            end
          end
          2'd1: begin
            shData[HalfW-1:0] <= wrData;
            shIsData <= 1'b1;
          end
          default: begin
            shData[CodeW-1:HalfW] <= wrData;
            shIsData <= 1'b1;
          end
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      2'd0: begin
        rdData[CtrlEnBit]   = shEn;
        rdData[CtrlTcBit]   = shTc;
        rdData[CtrlShBit]   = shSh;
        rdData[CtrlBusyBit] = busy;
        rdData[CtrlDoneBit] = doneFlag;
      end
      2'd1: rdData = shData[HalfW-1:0];
      2'd2: rdData = shData[CodeW-1:HalfW];
      default: rdData = '0;
    endcase
  end

  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> $stable({shEn, shTc, shSh, shIsData, reqTgl}));

  p_trim_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (shEn && wrEn) |=> $stable({shTc, shSh}));

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> doneFlag);

  p_pd_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerDown) |-> ($past(sleepReq) && doneFlag));
endmodule

// File: rtl/regcal_ctrl.sv
module regcal_ctrl
  import regcal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OSC_DIV = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startupDone,
  input  logic            sleepReq,
  input  logic            reqTgl,
  input  logic            shEn,
  input  logic            shIsData,
  output calStrobe_t      strb,
  output logic            running,
  output logic [IdxW-1:0] idx,
  output logic            ackTgl,
  output logic            doneTgl
);
  localparam int unsigned DivW = (OSC_DIV > 2) ? $clog2(OSC_DIV) : 1;
  localparam logic [DivW-1:0] DivLast = DivW'(OSC_DIV - 1);
  localparam logic [IdxW-1:0] IdxMsb = IdxW'(CodeW - 1);

  logic [DivW-1:0] divCnt;
  logic tick, reqS, sleepS, startS, pending, calEn, firstDone;
  logic [2:0] syncOut;
  calState_t st;

  regcal_sync #(.STAGES(SYNC_STAGES), .W(3)) uSyncIn (
    .clk(clk), .rstN(rstN), .d({reqTgl, sleepReq, startupDone}), .q(syncOut)
  );
  assign reqS   = syncOut[2];
  assign sleepS = syncOut[1];
  assign startS = syncOut[0];

  assign tick    = divCnt == DivLast;
  assign pending = reqS != ackTgl;
  assign running = st == ST_SAR;

  always_comb begin
    strb = '0;
    if (tick) begin
      if (pending) begin
        strb.loadTrim = 1'b1;
        strb.loadData = shIsData;
      end else if (running && calEn) begin
        strb.step  = 1'b1;
        strb.last  = idx == '0;
        strb.start = (idx == '0) && !sleepS;
      end else if (!running && calEn && startS && (!sleepS || !firstDone)) begin
        strb.start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      st        <= ST_IDLE;
      idx       <= IdxMsb;
      calEn     <= 1'b1;
      firstDone <= 1'b0;
      ackTgl    <= 1'b0;
      doneTgl   <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (strb.loadTrim) begin
        ackTgl <= reqS;
        calEn  <= shEn;
        if (!shEn) begin
          st  <= ST_IDLE;
          idx <= IdxMsb;
        end
      end else if (strb.step) begin
        if (strb.last) begin
          doneTgl   <= ~doneTgl;
          firstDone <= 1'b1;
          idx       <= IdxMsb;
          if (!strb.start) st <= ST_IDLE;
        end else begin
          idx <= idx - 1'b1;
        end
      end else if (strb.start) begin
        st  <= ST_SAR;
        idx <= IdxMsb;
      end
    end
  end

  p_idx_walk_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.last) |=> (idx == IdxW'($past(idx) - 1'b1)));

  p_sleep_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && !strb.start) |=> !running);

  p_disable_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTrim && !shEn) |=> !running);
endmodule

// File: rtl/regcal_dpath.sv
module regcal_dpath
  import regcal_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       strb,
  input  logic [IdxW-1:0]  idx,
  input  logic             running,
  input  logic             cmp,
  input  logic             shTc,
  input  logic             shSh,
  input  logic [CodeW-1:0] shData,
  output logic [CodeW-1:0] result,
  output logic [CodeW-1:0] regCode,
  output logic             regTempCo,
  output logic             regShort
);
  localparam logic [CodeW-1:0] MsbOnly = {1'b1, {(CodeW-1){1'b0}}};

  logic [CodeW-1:0] trial, nxt;

  always_comb begin
    nxt      = trial;
    nxt[idx] = cmp;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trial     <= '0;
      result    <= '0;
      regTempCo <= 1'b0;
      regShort  <= 1'b0;
    end else begin
      if (strb.loadTrim) begin
        regTempCo <= shTc;
        regShort  <= shSh;
        if (strb.loadData) result <= shData;
      end
      if (strb.step) begin
        trial <= strb.start ? MsbOnly : nxt;
        if (strb.last) result <= nxt;
      end else if (strb.start) begin
        trial <= MsbOnly;
      end
    end
  end

  assign regCode = running ? trial : result;

  p_bit_decided_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.last) |=> (trial[$past(idx)] == $past(cmp)));

  p_lsb_latched_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> (result[0] == $past(cmp)));

  p_hold_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.loadData) |=> (!running -> $stable(regCode)));
endmodule

// File: rtl/regcal_seq.sv
module regcal_seq
  import regcal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OSC_DIV = 2
) (
  input  logic        busClk,
  input  logic        busRstN,
  input  logic        oscClk,
  input  logic        oscRstN,
  input  logic        startupDone,
  input  logic        sleepReq,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [1:0]  rdAddr,
  output logic [7:0]  rdData,
  input  logic        cmpHigh,
  output logic        powerDown,
  output logic [15:0] regCode,
  output logic        regTempCo,
  output logic        regShort
);
  logic reqTgl, shEn, shTc, shSh, shIsData, ackTgl, doneTgl, running;
  logic [CodeW-1:0] shData, result;
  logic [IdxW-1:0] idx;
  calStrobe_t strb;

  regcal_busif #(.SYNC_STAGES(SYNC_STAGES)) uBus (
    .clk(busClk), .rstN(busRstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sleepReq(sleepReq), .powerDown(powerDown),
    .reqTgl(reqTgl), .shEn(shEn), .shTc(shTc), .shSh(shSh), .shIsData(shIsData),
    .shData(shData), .ackTglAsync(ackTgl), .doneTglAsync(doneTgl),
    .resultAsync(result)
  );

  regcal_ctrl #(.SYNC_STAGES(SYNC_STAGES), .OSC_DIV(OSC_DIV)) uCtrl (
    .clk(oscClk), .rstN(oscRstN), .startupDone(startupDone), .sleepReq(sleepReq),
    .reqTgl(reqTgl), .shEn(shEn), .shIsData(shIsData), .strb(strb),
    .running(running), .idx(idx), .ackTgl(ackTgl), .doneTgl(doneTgl)
  );

  regcal_dpath uDp (
    .clk(oscClk), .rstN(oscRstN), .strb(strb), .idx(idx), .running(running),
    .cmp(cmpHigh), .shTc(shTc), .shSh(shSh), .shData(shData), .result(result),
    .regCode(regCode), .regTempCo(regTempCo), .regShort(regShort)
  );
endmodule

// File: tb/regcal_seq_test.sv
module regcal_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_PERIOD = 70;
  localparam int CYCLE_WAIT = 10000;
  localparam int XFER_CYC = 60;

  typedef struct {
    int          kind;   // 0 register read, 1 powerDown, 2 regCode, 3 trims
    logic [1:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic busClk = 0, oscClk = 0, busRstN = 0, oscRstN = 0;
  logic startupDone = 0, sleepReq = 0, wrEn = 0;
  logic [1:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0, rdData;
  logic cmpHigh, powerDown, regTempCo, regShort;
  logic [15:0] regCode, target = 16'h0000;
  int compared = 0, mismatched = 0;
  bit finished = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) busClk = ~busClk;
  always #(OSC_PERIOD/2) oscClk = ~oscClk;

  // comparator model: high while the code is at or below the target
  assign cmpHigh = regCode <= target;

  regcal_seq uut (
    .busClk(busClk), .busRstN(busRstN), .oscClk(oscClk), .oscRstN(oscRstN),
    .startupDone(startupDone), .sleepReq(sleepReq), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .cmpHigh(cmpHigh),
    .powerDown(powerDown), .regCode(regCode), .regTempCo(regTempCo),
    .regShort(regShort)
  );

  // monitor: pops expected items and compares against the outputs
  initial begin
    item_t it;
    logic [15:0] act;
    forever begin
      @(negedge busClk);
      while (q.size() > 0) begin
        it = q.pop_front();
        case (it.kind)
          0: begin rdAddr = it.addr; #1; act = {8'h00, rdData}; end
          1: act = {15'b0, powerDown};
          2: act = regCode;
          default: act = {14'b0, regTempCo, regShort};
        endcase
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectItem(input int kind, input logic [1:0] addr,
                            input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
    q.push_back(it);
    while (q.size() != 0) @(negedge busClk);
  endtask

  task automatic busWrite(input logic [1:0] addr, input logic [7:0] data);
    @(negedge busClk);
    wrEn = 1; wrAddr = addr; wrData = data;
    @(negedge busClk);
    wrEn = 0;
  endtask

  task automatic waitBus(input int n);
    repeat (n) @(negedge busClk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(OSC_PERIOD * 3);
    busRstN = 1; oscRstN = 1;
    waitBus(5);
    // R1 reset values
    expectItem(0, 2'd0, 16'h0001, "R1 ctrl");
    expectItem(0, 2'd1, 16'h0000, "R1 data lo");
    expectItem(0, 2'd2, 16'h0000, "R1 data hi");
    expectItem(1, 0, 16'h0000, "R1 powerDown");

    // R4: sleep before any completion is held off
    target = 16'hA5C3;
    sleepReq = 1;
    waitBus(400);
    expectItem(1, 0, 16'h0000, "R4 powerDown held");
    expectItem(0, 2'd0, 16'h0001, "R4 no done yet");
    startupDone = 1;
    waitBus(CYCLE_WAIT / CLK_PERIOD);
    expectItem(0, 2'd0, 16'h0081, "R3 done set");
    expectItem(0, 2'd1, 16'h00C3, "R2 result lo");
    expectItem(0, 2'd2, 16'h00A5, "R2 result hi");
    expectItem(1, 0, 16'h0001, "R4 powerDown after done");
    expectItem(2, 0, 16'hA5C3, "R5 code held in sleep");

    // R5: stopped, comparator change has no effect
    target = 16'h3C0F;
    waitBus(CYCLE_WAIT / CLK_PERIOD);
    expectItem(2, 0, 16'hA5C3, "R5 code stable in sleep");
    expectItem(0, 2'd1, 16'h00C3, "R5 no new result in sleep");

    // R6: wake restarts calibration
    sleepReq = 0;
    waitBus(CYCLE_WAIT / CLK_PERIOD);
    expectItem(1, 0, 16'h0000, "R4 powerDown follows wake");
    expectItem(0, 2'd1, 16'h000F, "R6 new result lo");
    expectItem(0, 2'd2, 16'h003C, "R6 new result hi");

    // R7: data and trims locked while enabled
    busWrite(2'd1, 8'h11);
    waitBus(5);
    expectItem(0, 2'd1, 16'h000F, "R7 data write ignored");
    busWrite(2'd0, 8'h07);
    waitBus(XFER_CYC);
    expectItem(0, 2'd0, 16'h0081, "R7 trims ignored");

    // R9: disable stops search; R8 busy
    busWrite(2'd0, 8'h00);
    expectItem(0, 2'd0, 16'h00C0, "R8 busy after write");
    // R10: write while busy ignored
    busWrite(2'd1, 8'h55);
    waitBus(XFER_CYC);
    expectItem(0, 2'd0, 16'h0080, "R8 busy cleared");
    expectItem(0, 2'd1, 16'h000F, "R10 busy write ignored");
    target = 16'h7777;
    waitBus(CYCLE_WAIT / CLK_PERIOD);
    expectItem(2, 0, 16'h3C0F, "R9 code held when disabled");

    // R8: software takeover
    busWrite(2'd1, 8'h34);
    waitBus(XFER_CYC);
    busWrite(2'd2, 8'h12);
    waitBus(XFER_CYC);
    busWrite(2'd0, 8'h06);
    waitBus(XFER_CYC);
    expectItem(0, 2'd0, 16'h0086, "R8 ctrl written");
    expectItem(0, 2'd1, 16'h0034, "R8 data lo written");
    expectItem(0, 2'd2, 16'h0012, "R8 data hi written");
    expectItem(2, 0, 16'h1234, "R8 code applied");
    expectItem(3, 0, 16'h0003, "R8 trims applied");

    // R4: sleep while disabled passes through
    sleepReq = 1;
    waitBus(20);
    expectItem(1, 0, 16'h0001, "R4 powerDown while disabled");
    sleepReq = 0;
    waitBus(20);
    expectItem(1, 0, 16'h0000, "R4 powerDown released");

    // R2 extremes after re-enable
    target = 16'hFFFF;
    busWrite(2'd0, 8'h01);
    waitBus(XFER_CYC + CYCLE_WAIT / CLK_PERIOD);
    expectItem(0, 2'd0, 16'h0081, "R2 re-enabled ctrl");
    expectItem(0, 2'd1, 16'h00FF, "R2 max lo");
    expectItem(0, 2'd2, 16'h00FF, "R2 max hi");
    expectItem(3, 0, 16'h0000, "R2 trims cleared");
    target = 16'h0000;
    waitBus(CYCLE_WAIT / CLK_PERIOD);
    expectItem(0, 2'd1, 16'h0000, "R2 min lo");
    expectItem(0, 2'd2, 16'h0000, "R2 min hi");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule